// File: doc/BRIEF.md
# Priority Command Abort and Replay Unit

This block feeds a single converter command port from two command sources: an ordinary source and a high-priority source. The high-priority source delivers short sequences of conversion commands. Each sequence ends with a command that carries an end-of-sequence flag. In streaming use, the source sends the same sequence over and over. Commands pass through a valid/ready handshake on each source. On the converter side the block raises a start strobe together with the command, and then waits for a done pulse before it issues the next command.

A configuration input lets high-priority work preempt a conversion that is already running. With preemption enabled, a pending high-priority command while an ordinary or replayed command is in flight causes three things:
- the block sends a one-cycle abort pulse to the converter;
- it copies the interrupted command into a single save slot;
- it starts the high-priority sequence on the next cycle.

When the command that carries the end-of-sequence flag completes, the saved command is issued again, ahead of anything else. With preemption disabled, high-priority commands wait for the running conversion to finish and then win arbitration.

Top module: `prio_abort_replay`

## Requirements
- R1: After reset, and until a source presents a command, the outputs cv_start, cv_abort, pri_ready and nrm_ready are all 0.
- R2: Commands from the ordinary source are issued in arrival order. A command is started only when no conversion is in flight. A conversion is in flight from its start until cv_done or cv_abort.
- R3: When the converter is idle, no replay is pending and both sources are valid, the high-priority command is issued first.
- R4: When cfg_abort_en is 1 and pri_valid is 1 while an ordinary or replayed command is in flight and cv_done is 0, cv_abort is high for exactly one cycle. The high-priority command starts on the following cycle.
- R5: The aborted command is issued again with the same command value. This happens in the cycle after the high-priority end-of-sequence command completes, and before any further high-priority or ordinary command.
- R6: When cfg_abort_en is 0, cv_abort stays 0. A waiting high-priority command starts right after the running conversion's cv_done, ahead of a waiting ordinary command.
- R7: A command that came from the high-priority source is never aborted.
- R8: Only one command is ever saved. No abort occurs while a replay is still pending.
- R9: In streaming use, every new pass of the high-priority sequence preempts the replayed command again. The replay follows each pass, so the issue order is: command, abort, pass, replay, abort, pass, replay.
- R10: A high-priority sequence lasts until its end-of-sequence command (pri_eoq = 1) completes. If the high-priority source runs dry mid-sequence while a replay is pending, no ordinary command is issued in the gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_abort_en | input | 1 | 1 allows high-priority commands to preempt a running conversion |
| nrm_valid | input | 1 | Ordinary source has a command |
| nrm_cmd | input | CMD_W | Ordinary source command |
| nrm_ready | output | 1 | Ordinary command taken this cycle |
| pri_valid | input | 1 | High-priority source has a command |
| pri_cmd | input | CMD_W | High-priority command |
| pri_eoq | input | 1 | Command is the last of its sequence |
| pri_ready | output | 1 | High-priority command taken this cycle |
| cv_start | output | 1 | Start strobe to the converter |
| cv_cmd | output | CMD_W | Command issued with cv_start |
| cv_abort | output | 1 | One-cycle abort of the conversion in flight |
| cv_done | input | 1 | Converter finished the command in flight |

## Verification
The bench preempts an ordinary command and checks that the same value comes back only after the end-of-sequence command completes. A design that dropped the saved command would lose a conversion. A design that replayed too early would split the critical sequence. A streaming case repeats the sequence after the replay has started; a design that refused to abort a replayed command would delay the critical pass. The bench also leaves a gap in the high-priority sequence while an ordinary command waits. A design that filled the gap with the ordinary command would break the rule that the replay comes first. With preemption disabled, the bench confirms that no abort is sent and that the waiting high-priority command still overtakes the queued ordinary one.

// File: rtl/pra_pkg.sv
package pra_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_PRI  = 2'd1,
      SRC_NRM  = 2'd2,
      SRC_RPL  = 2'd3
   } src_e;

endpackage

// File: rtl/pra_select.sv
module pra_select
   import pra_pkg::*;
(
   input  logic idle,
   input  logic replay_pend,
   input  logic seq_active,
   input  logic pri_valid,
   input  logic nrm_valid,
   output src_e sel
);

   always_comb begin
      sel = SRC_NONE;
      if (idle) begin
         if (replay_pend && !seq_active)
            sel = SRC_RPL;
         else if (pri_valid)
            sel = SRC_PRI;
         else if (nrm_valid && !replay_pend)
            sel = SRC_NRM;
      end
   end

endmodule

// File: rtl/pra_abort_gen.sv
module pra_abort_gen #(
   parameter bit ALLOW_ABORT = 1'b1
) (
   input  logic cfg_abort_en,
   input  logic busy,
   input  logic cur_pri,
   input  logic replay_pend,
   input  logic pri_valid,
   input  logic cv_done,
   output logic abort
);

   generate
      if (ALLOW_ABORT) begin : g_abort
         assign abort = cfg_abort_en & busy & ~cur_pri & ~replay_pend
                        & pri_valid & ~cv_done;
      end else begin : g_no_abort
         logic unused_in;
         assign unused_in = cfg_abort_en ^ busy ^ cur_pri ^ replay_pend
                            ^ pri_valid ^ cv_done;
         assign abort = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pra_slot.sv
module pra_slot #(
   parameter int CMD_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             save,
   input  logic [CMD_W-1:0] save_cmd,
   input  logic             take,
   output logic             pend,
   output logic [CMD_W-1:0] held_cmd
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend     <= 1'b0;
         held_cmd <= '0;
      end else if (save) begin
         pend     <= 1'b1;
         held_cmd <= save_cmd;
      end else if (take) begin
         pend     <= 1'b0;
      end
   end

endmodule

// File: rtl/pra_seq_track.sv
module pra_seq_track (
   input  logic clk,
   input  logic rst_n,
   input  logic pri_issue,
   input  logic abort,
   input  logic seq_end,
   output logic seq_active
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seq_active <= 1'b0;
      else if (pri_issue || abort)
         seq_active <= 1'b1;
      else if (seq_end)
         seq_active <= 1'b0;
   end

endmodule

// File: rtl/prio_abort_replay.sv
module prio_abort_replay
   import pra_pkg::*;
#(
   parameter int CMD_W       = 16,
   parameter bit ALLOW_ABORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_abort_en,
   input  logic             nrm_valid,
   input  logic [CMD_W-1:0] nrm_cmd,
   output logic             nrm_ready,
   input  logic             pri_valid,
   input  logic [CMD_W-1:0] pri_cmd,
   input  logic             pri_eoq,
   output logic             pri_ready,
   output logic             cv_start,
   output logic [CMD_W-1:0] cv_cmd,
   output logic             cv_abort,
   input  logic             cv_done
);

   localparam int CMD_MSB = CMD_W - 1;

   generate
      if (CMD_W < 1) begin : g_bad_width
         $error("prio_abort_replay: CMD_W must be at least 1");
      end
   endgenerate

   logic             busy;
   logic             cur_pri;
   logic             cur_eoq;
   logic [CMD_MSB:0] cur_cmd;
   logic             replay_pend;
   logic [CMD_MSB:0] replay_cmd;
   logic             seq_active;
   logic             seq_end;
   logic             idle;
   src_e             sel;

   assign idle = rst_n & ~busy;

   pra_select u_select (
      .idle        (idle),
      .replay_pend (replay_pend),
      .seq_active  (seq_active),
      .pri_valid   (pri_valid),
      .nrm_valid   (nrm_valid),
      .sel         (sel)
   );

   pra_abort_gen #(.ALLOW_ABORT(ALLOW_ABORT)) u_abort (
      .cfg_abort_en (cfg_abort_en),
      .busy         (busy),
      .cur_pri      (cur_pri),
      .replay_pend  (replay_pend),
      .pri_valid    (pri_valid),
      .cv_done      (cv_done),
      .abort        (cv_abort)
   );

   pra_slot #(.CMD_W(CMD_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .save     (cv_abort),
      .save_cmd (cur_cmd),
      .take     (sel == SRC_RPL),
      .pend     (replay_pend),
      .held_cmd (replay_cmd)
   );

   assign seq_end = busy & cv_done & cur_pri & cur_eoq;

   pra_seq_track u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .pri_issue  (sel == SRC_PRI),
      .abort      (cv_abort),
      .seq_end    (seq_end),
      .seq_active (seq_active)
   );

   always_comb begin
      unique case (sel)
         SRC_PRI: cv_cmd = pri_cmd;
         SRC_NRM: cv_cmd = nrm_cmd;
         SRC_RPL: cv_cmd = replay_cmd;
         default: cv_cmd = '0;
      endcase
   end

   assign cv_start  = (sel != SRC_NONE);
   assign pri_ready = (sel == SRC_PRI);
   assign nrm_ready = (sel == SRC_NRM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         cur_pri <= 1'b0;
         cur_eoq <= 1'b0;
         cur_cmd <= '0;
      end else begin
         if (cv_abort)
            busy <= 1'b0;
         else if (cv_start)
            busy <= 1'b1;
         else if (cv_done)
            busy <= 1'b0;
         if (cv_start) begin
            cur_cmd <= cv_cmd;
            cur_pri <= (sel == SRC_PRI);
            cur_eoq <= (sel == SRC_PRI) & pri_eoq;
         end
      end
   end

endmodule

// File: rtl/pra_checker.sv
module pra_checker (
   input logic clk,
   input logic rst_n,
   input logic cfg_abort_en,
   input logic nrm_ready,
   input logic pri_valid,
   input logic pri_ready,
   input logic cv_start,
   input logic cv_abort,
   input logic cv_done
);

   logic c_busy;
   logic c_pri;
   logic c_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_busy <= 1'b0;
         c_pri  <= 1'b0;
         c_pend <= 1'b0;
      end else begin
         if (cv_abort)      c_busy <= 1'b0;
         else if (cv_start) c_busy <= 1'b1;
         else if (cv_done)  c_busy <= 1'b0;
         if (cv_start) c_pri <= pri_ready;
         if (cv_abort)
            c_pend <= 1'b1;
         else if (cv_start && !pri_ready && !nrm_ready)
            c_pend <= 1'b0;
      end
   end

   a_r2_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cv_start |-> !c_busy);

   a_r2_one_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (pri_ready || nrm_ready) |-> (cv_start && !(pri_ready && nrm_ready)));

   a_r3_pri_first: assert property (@(posedge clk) disable iff (!rst_n)
      (cv_start && pri_valid && !c_pend) |-> pri_ready);

   a_r4_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cv_abort |=> !cv_abort);

   a_r4_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
      cv_abort |-> (pri_valid && c_busy && !cv_done));

   a_r4_pri_follows: assert property (@(posedge clk) disable iff (!rst_n)
      cv_abort |=> (pri_valid -> pri_ready));

   a_r5_replay_before_normal: assert property (@(posedge clk) disable iff (!rst_n)
      nrm_ready |-> !c_pend);

   a_r6_no_abort_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_abort_en |-> !cv_abort);

   a_r7_pri_not_aborted: assert property (@(posedge clk) disable iff (!rst_n)
      cv_abort |-> !c_pri);

   a_r8_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
      cv_abort |-> !c_pend);

endmodule

bind prio_abort_replay pra_checker u_pra_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_abort_en (cfg_abort_en),
   .nrm_ready    (nrm_ready),
   .pri_valid    (pri_valid),
   .pri_ready    (pri_ready),
   .cv_start     (cv_start),
   .cv_abort     (cv_abort),
   .cv_done      (cv_done)
);

// File: tb/prio_abort_replay_tb.sv
module prio_abort_replay_tb;

   localparam int CMD_W = 16;
   localparam int LAT   = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_abort_en = 1'b1;
   logic             nrm_valid = 1'b0;
   logic [CMD_W-1:0] nrm_cmd = '0;
   logic             nrm_ready;
   logic             pri_valid = 1'b0;
   logic [CMD_W-1:0] pri_cmd = '0;
   logic             pri_eoq = 1'b0;
   logic             pri_ready;
   logic             cv_start;
   logic [CMD_W-1:0] cv_cmd;
   logic             cv_abort;
   logic             cv_done = 1'b0;

   always #5 clk = ~clk;

   prio_abort_replay #(.CMD_W(CMD_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_abort_en(cfg_abort_en),
      .nrm_valid(nrm_valid), .nrm_cmd(nrm_cmd), .nrm_ready(nrm_ready),
      .pri_valid(pri_valid), .pri_cmd(pri_cmd), .pri_eoq(pri_eoq),
      .pri_ready(pri_ready), .cv_start(cv_start), .cv_cmd(cv_cmd),
      .cv_abort(cv_abort), .cv_done(cv_done)
   );

   int checks = 0;
   int fails  = 0;
   int n_issue = 0;
   int n_abort = 0;
   bit m_busy = 1'b0;
   int m_cnt  = 0;

   logic [CMD_W-1:0] nq[$];
   logic [CMD_W:0]   pq[$];
   logic [CMD_W:0]   exp_q[$];
   string            tag_q[$];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic exp_issue(input logic [CMD_W-1:0] c, input string tag);
      exp_q.push_back({1'b0, c});
      tag_q.push_back(tag);
   endtask

   task automatic exp_abort(input string tag);
      exp_q.push_back({1'b1, {CMD_W{1'b0}}});
      tag_q.push_back(tag);
   endtask

   task automatic sb_compare(input logic [CMD_W:0] act);
      if (exp_q.size() == 0) begin
         chk(1'b0, "scoreboard-unexpected", int'(act), 0);
      end else begin
         logic [CMD_W:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(act == e, t, int'(act), int'(e));
      end
   endtask

   // cycle engine: converter model, source drivers and monitor
   always begin
      @(negedge clk);
      if (m_busy) begin
         if (m_cnt == 0) begin
            cv_done = 1'b1;
            m_busy  = 1'b0;
         end else begin
            m_cnt--;
            cv_done = 1'b0;
         end
      end else begin
         cv_done = 1'b0;
      end
      nrm_valid = (nq.size() != 0);
      nrm_cmd   = nrm_valid ? nq[0] : '0;
      pri_valid = (pq.size() != 0);
      {pri_eoq, pri_cmd} = pri_valid ? pq[0] : '0;
      #4;
      if (rst_n) begin
         if (cv_abort) begin
            m_busy = 1'b0;
            n_abort++;
            sb_compare({1'b1, {CMD_W{1'b0}}});
         end
         if (cv_start) begin
            m_busy = 1'b1;
            m_cnt  = LAT;
            n_issue++;
            sb_compare({1'b0, cv_cmd});
         end
         if (nrm_ready && nq.size() != 0) nq.delete(0);
         if (pri_ready && pq.size() != 0) pq.delete(0);
      end
   end

   task automatic at_slot();
      @(posedge clk);
      #2;
   endtask

   task automatic wait_issues(input int n);
      while (n_issue < n) at_slot();
   endtask

   task automatic drain(input string tag, input int ab_base, input int ab_exp);
      int guard = 0;
      while ((exp_q.size() != 0 || nq.size() != 0 || pq.size() != 0 || m_busy)
             && guard < 2000) begin
         at_slot();
         guard++;
      end
      repeat (4) at_slot();
      chk(exp_q.size() == 0, {tag, " all expected items seen"}, exp_q.size(), 0);
      chk(n_abort - ab_base == ab_exp, {tag, " abort count"}, n_abort - ab_base, ab_exp);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
   end

   initial begin
      int base;
      int ab;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk(cv_start == 1'b0, "R1 cv_start in reset", cv_start, 0);
      chk(cv_abort == 1'b0, "R1 cv_abort in reset", cv_abort, 0);
      rst_n = 1'b1;
      repeat (2) at_slot();
      chk({cv_start, cv_abort, pri_ready, nrm_ready} == 4'b0, "R1 idle after reset",
          {cv_start, cv_abort, pri_ready, nrm_ready}, 0);

      // R2: ordinary commands in order
      ab = n_abort;
      exp_issue(16'h0101, "R2 order first");
      exp_issue(16'h0102, "R2 order second");
      exp_issue(16'h0103, "R2 order third");
      at_slot();
      nq.push_back(16'h0101); nq.push_back(16'h0102); nq.push_back(16'h0103);
      drain("R2", ab, 0);

      // R4/R5: abort and replay
      ab = n_abort;
      base = n_issue;
      exp_issue(16'h0201, "R2 ordinary start");
      exp_abort("R4 abort pulse");
      exp_issue(16'h8A01, "R4 pri starts after abort");
      exp_issue(16'h8A02, "R10 sequence continues");
      exp_issue(16'h0201, "R5 replay of aborted command");
      exp_issue(16'h0202, "R5 ordinary after replay");
      at_slot();
      nq.push_back(16'h0201);
      wait_issues(base + 1);
      repeat (2) at_slot();
      pq.push_back({1'b0, 16'h8A01});
      pq.push_back({1'b1, 16'h8A02});
      nq.push_back(16'h0202);
      drain("R4", ab, 1);

      // R6: abort disabled
      cfg_abort_en = 1'b0;
      ab = n_abort;
      base = n_issue;
      exp_issue(16'h0301, "R6 ordinary start");
      exp_issue(16'h8B01, "R6 pri waits then wins");
      exp_issue(16'h0302, "R6 ordinary after pri");
      at_slot();
      nq.push_back(16'h0301);
      wait_issues(base + 1);
      repeat (2) at_slot();
      pq.push_back({1'b1, 16'h8B01});
      nq.push_back(16'h0302);
      drain("R6", ab, 0);
      cfg_abort_en = 1'b1;

      // R9: streaming repeat preempts replay again
      ab = n_abort;
      base = n_issue;
      exp_issue(16'h0401, "R9 ordinary start");
      exp_abort("R9 first abort");
      exp_issue(16'h8C01, "R9 pass one a");
      exp_issue(16'h8C02, "R9 pass one b");
      exp_issue(16'h0401, "R9 first replay");
      exp_abort("R9 replay aborted by next pass");
      exp_issue(16'h8C01, "R9 pass two a");
      exp_issue(16'h8C02, "R9 pass two b");
      exp_issue(16'h0401, "R9 second replay");
      at_slot();
      nq.push_back(16'h0401);
      wait_issues(base + 1);
      repeat (2) at_slot();
      pq.push_back({1'b0, 16'h8C01});
      pq.push_back({1'b1, 16'h8C02});
      wait_issues(base + 4);
      repeat (2) at_slot();
      pq.push_back({1'b0, 16'h8C01});
      pq.push_back({1'b1, 16'h8C02});
      drain("R9", ab, 2);

      // R3: both sources valid while idle
      ab = n_abort;
      exp_issue(16'h8D01, "R3 pri first when idle");
      exp_issue(16'h0501, "R3 ordinary second");
      at_slot();
      pq.push_back({1'b1, 16'h8D01});
      nq.push_back(16'h0501);
      drain("R3", ab, 0);

      // R10: gap in the sequence holds ordinary source
      ab = n_abort;
      base = n_issue;
      exp_issue(16'h0601, "R10 ordinary start");
      exp_abort("R10 abort");
      exp_issue(16'h8E01, "R10 pri first part");
      exp_issue(16'h8E02, "R10 pri end");
      exp_issue(16'h0601, "R10 replay");
      exp_issue(16'h0602, "R10 ordinary after replay");
      at_slot();
      nq.push_back(16'h0601);
      wait_issues(base + 1);
      repeat (2) at_slot();
      pq.push_back({1'b0, 16'h8E01});
      wait_issues(base + 2);
      nq.push_back(16'h0602);
      repeat (3 * LAT) at_slot();
      chk(n_issue == base + 2, "R10 nothing issued in gap", n_issue - base, 2);
      pq.push_back({1'b1, 16'h8E02});
      drain("R10", ab, 1);

      summary();
   end

endmodule